// File: doc/BRIEF.md
# Timeslice Hit Monitor with Snapshot Packet

The block keeps a saturating hit counter for each of 31 detector channels. Each timeslice start pulse does three things at once. It copies every live counter into a snapshot register. It restarts the live counters for the new slice. It raises a one-cycle interrupt to the local processor. The processor then has the whole new slice to fill a fixed section of dual-port RAM with monitoring data.

The same pulse sets a busy bit and starts a packet sequencer. The sequencer emits the latched counts, then the RAM section, as one packet on a valid/ready word stream. Each packet therefore carries the counts of slice n-1 while counting continues for slice n. Busy stays set until the final word of the packet is accepted. The processor polls busy to learn when the RAM section is free to be written again.

A start pulse can arrive while a packet is still in flight. In that case the pulse is flagged in a sticky overrun bit and the snapshot is still taken. The running packet finishes, and a further packet for the newest snapshot follows at once.

Top module: `ts_monitor`

## Requirements
- R1: Each channel i (0 to NCH-1) has a CW-bit counter. The counter rises by one on every cycle in which hit[i] is high. It holds at 2^CW-1 and never wraps.
- R2: In a cycle where slice_start is high, each counter value moves into its snapshot register. The live counter then restarts at 1 if hit[i] is high in that same cycle, and at 0 otherwise.
- R3: irq is high for exactly the one cycle that follows each cycle in which slice_start is high.
- R4: A packet has NCH+RAM_WORDS words. Words 0 to NCH-1 are the snapshots of channels 0 upward, each in the low CW bits with the upper bits zero. The RAM words follow for addresses 0 upward. out_last is high only on the final word.
- R5: To fetch each RAM word, ram_rd is high for one cycle with ram_addr set to the word address. The word is then taken from ram_rdata, which must hold its value until the next read.
- R6: While out_ready stays high, out_valid first rises two cycles after the slice_start cycle, and one word is accepted every two cycles.
- R7: While out_valid is high and out_ready is low, out_data and out_last hold steady. Every word is delivered exactly once.
- R8: Status bit 0 (busy) goes high in the cycle after slice_start. It goes low in the cycle after the final word is accepted, unless a further packet is pending.
- R9: When slice_start arrives while busy is high, status bit 1 (overrun) is set and stays set. The snapshot is still taken. The current packet completes, and a new packet then starts at once with busy held high.
- R10: A cycle with stat_wr high and stat_wdata equal to 1 clears overrun. stat_wdata equal to 0 leaves overrun unchanged. If an overrun event occurs in the same cycle as a clear, overrun is set.
- R11: After reset, status is 0, out_valid, irq and ram_rd are low, and all counters and snapshots are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit | input | NCH | Per-channel hit strobes |
| slice_start | input | 1 | Timeslice start pulse |
| irq | output | 1 | Interrupt pulse to the local processor |
| ram_rd | output | 1 | RAM read strobe |
| ram_addr | output | AW | RAM word address |
| ram_rdata | input | DW | RAM read data, one cycle after ram_rd |
| out_valid | output | 1 | Stream word valid |
| out_ready | input | 1 | Stream sink ready |
| out_data | output | DW | Stream word |
| out_last | output | 1 | Final word of packet |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 1 | Written to overrun: 1 clears |
| status | output | 2 | Bit 1 overrun, bit 0 busy |

## Verification
The counters are driven with a staircase pattern in which channel i receives i hits. Any swap, loss or offset between channels then shows up in the word order of the packet. A slice carries hits coincident with the start pulse, plus a long burst on one channel beyond saturation. This separates counting into the new slice from counting into the old one, and separates saturation from wrap. The packet is drained once with a continuously ready sink, to pin the two-cycle pacing and latency, and once with an irregular ready pattern, to expose lost, repeated or unstable words. Back-to-back start pulses during a packet, including one that coincides with an overrun clear write, distinguish sticky overrun, set priority and the chained packet from a design that simply drops the second slice.

// File: rtl/ts_monitor.sv
module ts_monitor #(
  parameter int NCH       = 31,
  parameter int CW        = 16,
  parameter int DW        = 32,
  parameter int RAM_WORDS = 32,
  localparam int AW       = (RAM_WORDS > 1) ? $clog2(RAM_WORDS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hit,
  input  logic           slice_start,
  output logic           irq,
  output logic           ram_rd,
  output logic [AW-1:0]  ram_addr,
  input  logic [DW-1:0]  ram_rdata,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DW-1:0]  out_data,
  output logic           out_last,
  input  logic           stat_wr,
  input  logic           stat_wdata,
  output logic [1:0]     status
);
  localparam int NW  = NCH + RAM_WORDS;
  localparam int IW  = $clog2(NW + 1);
  localparam int CIW = (NCH > 1) ? $clog2(NCH) : 1;

  typedef enum logic [1:0] {IDLE, FETCH, SEND} ph_t;

  logic [CW-1:0] cnt  [NCH];
  logic [CW-1:0] snap [NCH];
  logic [CW-1:0] word_q;
  ph_t           ph;
  logic [IW-1:0] idx;
  logic          busy_q, ovr_q, pend_q;
  logic          is_cnt, hs, fin;

  assign is_cnt    = idx < IW'(NCH);
  assign out_valid = (ph == SEND);
  assign out_last  = out_valid && (idx == IW'(NW - 1));
  assign out_data  = is_cnt ? DW'(word_q) : ram_rdata;
  assign ram_rd    = (ph == FETCH) && !is_cnt;
  assign ram_addr  = AW'(idx - IW'(NCH));
  assign hs        = out_valid && out_ready;
  assign fin       = hs && out_last;
  assign status    = {ovr_q, busy_q};

  always_ff @(posedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (!rst_n) begin
        cnt[i]  <= '0;
        snap[i] <= '0;
      end else if (slice_start) begin
        snap[i] <= cnt[i];
        cnt[i]  <= CW'(hit[i]);
      end else if (hit[i] && cnt[i] != {CW{1'b1}}) begin
        cnt[i]  <= cnt[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= IDLE;
      idx    <= '0;
      word_q <= '0;
    end else begin
      case (ph)
        IDLE: if (slice_start) begin
          ph  <= FETCH;
          idx <= '0;
        end
        FETCH: begin
          if (is_cnt) word_q <= snap[idx[CIW-1:0]];
          ph <= SEND;
        end
        default: if (hs) begin
          if (out_last) begin
            ph  <= (pend_q || slice_start) ? FETCH : IDLE;
            idx <= '0;
          end else begin
            ph  <= FETCH;
            idx <= idx + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ovr_q  <= 1'b0;
      pend_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      irq <= slice_start;
      if (slice_start)        busy_q <= 1'b1;
      else if (fin && !pend_q) busy_q <= 1'b0;
      if (fin)                          pend_q <= 1'b0;
      else if (slice_start && busy_q)   pend_q <= 1'b1;
      if (slice_start && busy_q)        ovr_q <= 1'b1;
      else if (stat_wr && stat_wdata)   ovr_q <= 1'b0;
    end
  end
endmodule

module ts_monitor_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slice_start,
  input logic          irq,
  input logic          ram_rd,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_last,
  input logic          busy,
  input logic          overrun
);
  assert_irq_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> busy);
  assert_last_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  assert_ram_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd |=> (out_valid && !ram_rd));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
  assert_busy_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slice_start |=> busy);
  assert_busy_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(out_valid && out_ready && out_last));
  assert_overrun_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (slice_start && busy) |=> (overrun && busy));
  assert_overrun_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(slice_start && busy));
endmodule

bind ts_monitor ts_monitor_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .slice_start(slice_start), .irq(irq),
  .ram_rd(ram_rd), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last),
  .busy(status[0]), .overrun(status[1])
);

// File: tb/test_ts_monitor.sv
module test_ts_monitor;
  localparam int NCH  = 31;
  localparam int CW   = 8;
  localparam int DW   = 32;
  localparam int RW   = 32;
  localparam int AW   = 5;
  localparam int NW   = NCH + RW;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst_n = 1'b0;
  logic [NCH-1:0] hit = '0;
  logic           slice_start = 1'b0;
  logic           irq, ram_rd, out_valid, out_last;
  logic [AW-1:0]  ram_addr;
  logic [DW-1:0]  ram_rdata = '0;
  logic [DW-1:0]  out_data;
  logic           out_ready = 1'b1;
  logic           stat_wr = 1'b0, stat_wdata = 1'b0;
  logic [1:0]     status;

  ts_monitor #(.NCH(NCH), .CW(CW), .DW(DW), .RAM_WORDS(RW)) i_ts_monitor (
    .clk(clk), .rst_n(rst_n), .hit(hit), .slice_start(slice_start), .irq(irq),
    .ram_rd(ram_rd), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .status(status)
  );

  logic [DW-1:0] mem [RW];
  always @(posedge clk) if (ram_rd) ram_rdata <= mem[ram_addr];

  int checks = 0, fails = 0, cyc = 0;
  int m_cnt [NCH];
  int m_snap [NCH];
  int m_ph = 0, m_idx = 0, m_busy = 0, m_ovr = 0, m_pend = 0, m_irq = 0;
  logic [DW-1:0] m_word = '0;
  logic [DW-1:0] pkt [$];
  int            pcyc [$];
  int            lastq [$];
  logic          p_hold = 1'b0;
  logic [DW-1:0] p_data = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin : model
    int bo, hsv, finv;
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin m_cnt[i] = 0; m_snap[i] = 0; end
      m_ph = 0; m_idx = 0; m_busy = 0; m_ovr = 0; m_pend = 0; m_irq = 0; m_word = '0;
    end else begin
      bo   = m_busy;
      hsv  = (m_ph == 2 && out_ready) ? 1 : 0;
      finv = (hsv != 0 && m_idx == NW - 1) ? 1 : 0;
      if (m_ph == 1 && m_idx < NCH) m_word = DW'(m_snap[m_idx]);
      case (m_ph)
        0: if (slice_start) begin m_ph = 1; m_idx = 0; end
        1: m_ph = 2;
        default: if (hsv != 0) begin
          if (finv != 0) begin
            if (m_pend != 0 || slice_start) begin m_ph = 1; m_idx = 0; end
            else m_ph = 0;
          end else begin
            m_idx++; m_ph = 1;
          end
        end
      endcase
      if (slice_start) m_busy = 1;
      else if (finv != 0 && m_pend == 0) m_busy = 0;
      if (finv != 0) m_pend = 0;
      else if (slice_start && bo != 0) m_pend = 1;
      if (slice_start && bo != 0) m_ovr = 1;
      else if (stat_wr && stat_wdata) m_ovr = 0;
      m_irq = slice_start ? 1 : 0;
      for (int i = 0; i < NCH; i++) begin
        if (slice_start) begin m_snap[i] = m_cnt[i]; m_cnt[i] = hit[i] ? 1 : 0; end
        else if (hit[i] && m_cnt[i] < MAXC) m_cnt[i]++;
      end
    end
  end

  always @(negedge clk) begin : monitor
    logic ev, el, erd;
    logic [DW-1:0] ed;
    cyc++;
    ev  = (m_ph == 2);
    el  = ev && (m_idx == NW - 1);
    ed  = (m_idx < NCH) ? m_word : mem[m_idx - NCH];
    erd = (m_ph == 1) && (m_idx >= NCH);
    chk(out_valid == ev && out_last == el && (!ev || out_data == ed), "R4 stream word",
        {30'd0, out_valid, out_last, out_data}, {30'd0, ev, el, ed});
    chk(status == {m_ovr[0], m_busy[0]}, "R8 status", 64'(status), 64'({m_ovr[0], m_busy[0]}));
    chk(irq == m_irq[0], "R3 irq", 64'(irq), 64'(m_irq[0]));
    chk(ram_rd == erd && (!erd || 32'(ram_addr) == 32'(m_idx - NCH)), "R5 ram read",
        {ram_rd, 58'd0, ram_addr}, {erd, 58'd0, AW'(m_idx - NCH)});
    if (p_hold)
      chk(out_valid && out_data == p_data, "R7 hold under stall", 64'(out_data), 64'(p_data));
    p_hold = out_valid && !out_ready;
    p_data = out_data;
    if (out_valid && out_ready) begin
      pkt.push_back(out_data);
      pcyc.push_back(cyc);
      lastq.push_back(out_last ? 1 : 0);
    end
  end

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic pulse_start();
    slice_start = 1'b1;
    tick();
    slice_start = 1'b0;
  endtask

  task automatic wait_idle();
    do begin
      @(negedge clk);
      #1;
    end while (status[0]);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin : driver
    int n0, nl;
    logic [15:0] lf;
    for (int j = 0; j < RW; j++) mem[j] = 32'hA500_0000 + 32'(j * 3);
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    @(negedge clk); #1;
    chk(status == 2'b00 && !out_valid && !irq && !ram_rd, "R11 reset state",
        {58'd0, status, out_valid, irq, ram_rd}, 64'd0);

    // staircase: channel i gets i hits
    for (int k = 0; k < 40; k++) begin
      for (int i = 0; i < NCH; i++) hit[i] = (k < i);
      tick();
    end
    hit = '0;
    pkt.delete(); pcyc.delete(); lastq.delete();
    pulse_start();
    @(negedge clk); #1;
    n0 = cyc;
    chk(irq && !out_valid, "R3 irq after start", {62'd0, irq, out_valid}, 64'd2);
    @(negedge clk); #1;
    chk(!irq && out_valid, "R6 first word latency", {62'd0, irq, out_valid}, 64'd1);
    wait_idle();
    chk(pkt.size() == NW, "R4 packet length", 64'(pkt.size()), 64'(NW));
    for (int i = 0; i < NCH; i++) chk(pkt[i] == DW'(i), "R1 staircase count", 64'(pkt[i]), 64'(i));
    for (int j = 0; j < RW; j++) chk(pkt[NCH + j] == mem[j], "R5 ram word", 64'(pkt[NCH + j]), 64'(mem[j]));
    chk(pcyc[0] == n0 + 1, "R6 first accept cycle", 64'(pcyc[0]), 64'(n0 + 1));
    chk(pcyc[NW - 1] - pcyc[0] == 2 * (NW - 1), "R6 two cycles per word",
        64'(pcyc[NW - 1] - pcyc[0]), 64'(2 * (NW - 1)));
    nl = 0;
    for (int i = 0; i < NW; i++) nl += lastq[i];
    chk(nl == 1 && lastq[NW - 1] == 1, "R4 single last flag", 64'(nl), 64'd1);
    chk(status == 2'b00, "R8 busy cleared", 64'(status), 64'd0);

    // coincident hits on channels 0..3
    for (int j = 0; j < RW; j++) mem[j] = ~(32'(j) * 32'h0101_0101);
    pkt.delete(); pcyc.delete(); lastq.delete();
    hit[3:0] = 4'hF;
    pulse_start();
    hit = '0;
    wait_idle();
    nl = 0;
    for (int i = 0; i < NCH; i++) nl += int'(pkt[i]);
    chk(nl == 0, "R2 coincident hits not in old slice", 64'(nl), 64'd0);

    // saturation burst on channel 5, then drain with backpressure
    hit[5] = 1'b1;
    repeat (300) tick();
    hit = '0;
    pkt.delete(); pcyc.delete(); lastq.delete();
    lf = 16'hACE1;
    pulse_start();
    do begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      out_ready = lf[0] | lf[3];
      tick();
    end while (status[0]);
    out_ready = 1'b1;
    chk(pkt.size() == NW, "R7 no word lost or repeated", 64'(pkt.size()), 64'(NW));
    for (int i = 0; i < 4; i++) chk(pkt[i] == 1, "R2 restart at one", 64'(pkt[i]), 64'd1);
    chk(pkt[4] == 0, "R2 idle channel zero", 64'(pkt[4]), 64'd0);
    chk(pkt[5] == MAXC, "R1 saturation", 64'(pkt[5]), 64'(MAXC));
    for (int j = 0; j < RW; j++) chk(pkt[NCH + j] == mem[j], "R5 ram word under stall", 64'(pkt[NCH + j]), 64'(mem[j]));

    // overrun: second start while busy
    pkt.delete(); pcyc.delete(); lastq.delete();
    pulse_start();
    repeat (10) tick();
    pulse_start();
    @(negedge clk); #1;
    chk(status == 2'b11, "R9 overrun and busy", 64'(status), 64'd3);
    wait_idle();
    chk(pkt.size() == 2 * NW, "R9 chained packet", 64'(pkt.size()), 64'(2 * NW));
    nl = 0;
    for (int i = 0; i < pkt.size(); i++) nl += lastq[i];
    chk(nl == 2, "R9 two last flags", 64'(nl), 64'd2);
    chk(status == 2'b10, "R9 overrun sticky", 64'(status), 64'd2);
    stat_wr = 1'b1; stat_wdata = 1'b0;
    tick();
    stat_wr = 1'b0;
    @(negedge clk); #1;
    chk(status[1], "R10 write zero keeps overrun", 64'(status), 64'd2);
    stat_wr = 1'b1; stat_wdata = 1'b1;
    tick();
    stat_wr = 1'b0; stat_wdata = 1'b0;
    @(negedge clk); #1;
    chk(!status[1], "R10 write one clears overrun", 64'(status), 64'd0);

    // set wins over a same-cycle clear
    pulse_start();
    repeat (4) tick();
    slice_start = 1'b1; stat_wr = 1'b1; stat_wdata = 1'b1;
    tick();
    slice_start = 1'b0; stat_wr = 1'b0; stat_wdata = 1'b0;
    @(negedge clk); #1;
    chk(status == 2'b11, "R10 set beats clear", 64'(status), 64'd3);
    wait_idle();
    repeat (3) tick();
    report();
  end
endmodule